// File: doc/BRIEF.md
# Ping-Pong Endpoint Buffer with DMA Handshake

This block is the large-data endpoint store of a USB device controller. It holds two equal packet buffers and passes them back and forth between two owners: the USB side (the protocol engine) and the local side (a CPU or a DMA engine). While one owner fills or drains one buffer, the other owner works on the second buffer. Ownership changes hands by itself when a packet ends, when the local side has consumed a whole packet, or when the USB side has finished sending one. Software never moves a pointer.

A direction input selects OUT traffic or IN traffic. For OUT, the USB side writes and the local side reads. For IN, the local side writes, validates, and the USB side reads. Two mode inputs set the buffer size. Bulk and interrupt traffic use 64 bytes per buffer. Isochronous traffic in one direction uses 128 bytes per buffer. Isochronous traffic with both directions active uses 64 bytes per buffer.

A DMA engine is started with a pulse. It is then served by a request output, an active-low acknowledge input and an active-low end-of-transfer input. Back-to-back DMA strobes run across the boundary between the two buffers with no CPU step in between. Mode and direction are expected to change only while reset is asserted.

Top module: `ep_dbuf_dma`

## Requirements
- R1: There are two buffers. `buf_full_o[b]` is 1 while buffer b holds a packet for its consumer. Both sides start on buffer 0, and each side moves to the other buffer on its own when it hands a buffer over. A full flag changes only in a cycle that has a packet-end, done, read, write or validate strobe.
- R2: Per-buffer capacity is 64 bytes when `iso_i`=0. It is 128 bytes when `iso_i`=1 and `iso_dual_i`=0, and 64 bytes when both are 1. Bytes offered beyond the capacity are dropped, so a count never exceeds the capacity.
- R3: OUT (`dir_in_i`=0): `usb_wr_i` stores `usb_wdata_i` into the USB-side buffer. `usb_eop_i` marks that buffer full, and its count is the number of bytes accepted, including a write in the same cycle. The local side then sees `loc_ready_o`=1 and `loc_cnt_o` equal to that count.
- R4: OUT: `loc_rdata_o` shows the next unread byte of the local buffer. Each `loc_rd_i` advances one byte. After the last counted byte is read, the buffer becomes empty and the local side moves to the other buffer.
- R5: OUT: while the USB-side buffer is still full (both buffers full), `usb_nak_o`=1. Writes and packet ends in this state are ignored and leave the stored data untouched.
- R6: IN (`dir_in_i`=1): `loc_wr_i` stores bytes while `loc_ready_o`=1. The buffer is committed (full, count = bytes written) on `loc_validate_i`, on the write that reaches the capacity, or on a write that carries an accepted end-of-transfer. The local side then moves to the other buffer.
- R7: IN: `usb_nak_o`=1 while the USB-side buffer is not committed. Otherwise `usb_cnt_o` gives its count and `usb_rdata_o` its next byte. `usb_rd_i` advances one byte, and `usb_done_i` frees the buffer and moves the USB side to the other one.
- R8: `dma_start_i` arms the DMA. While armed, `dma_req_o` = `loc_ready_o`. While not armed (including after reset), `dma_req_o`=0.
- R9: End-of-transfer is accepted only when `dma_eot_n_i`=0, `dma_ack_n_i`=0 and a local read or write strobe are all present in the same cycle. An accepted end on an OUT read releases the buffer, dropping any unread bytes. On an IN write it commits the buffer. It also disarms the DMA, so `dma_req_o` is 0 from the next cycle on.
- R10: Consecutive local strobes drain or fill across both buffers in order without any other input, and the data stay continuous across the boundary.
- R11: An OUT packet end and the local release of the other buffer in the same cycle both take effect.
- R12: After reset both buffers are empty, both sides are on buffer 0, and the DMA is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iso_i | input | 1 | Isochronous sizing |
| iso_dual_i | input | 1 | Both isochronous directions active |
| dir_in_i | input | 1 | 0 = OUT traffic, 1 = IN traffic |
| usb_wr_i | input | 1 | USB-side byte write (OUT) |
| usb_wdata_i | input | 8 | USB-side write byte |
| usb_eop_i | input | 1 | USB OUT packet complete |
| usb_rd_i | input | 1 | USB-side byte read (IN) |
| usb_done_i | input | 1 | USB side finished sending the buffer (IN) |
| usb_rdata_o | output | 8 | Next byte for the USB side |
| usb_cnt_o | output | CNT_W (8) | OUT: bytes written so far; IN: committed count |
| usb_nak_o | output | 1 | OUT: no room; IN: nothing to send |
| loc_rd_i | input | 1 | Local or DMA byte read (OUT) |
| loc_wr_i | input | 1 | Local or DMA byte write (IN) |
| loc_wdata_i | input | 8 | Local write byte |
| loc_validate_i | input | 1 | Commit the local buffer (IN) |
| loc_rdata_o | output | 8 | Next byte for the local side |
| loc_cnt_o | output | CNT_W (8) | OUT: committed count; IN: bytes written so far |
| loc_ready_o | output | 1 | Local buffer has data (OUT) or space (IN) |
| buf_full_o | output | 2 | Full flag per buffer |
| dma_start_i | input | 1 | Arm the DMA |
| dma_ack_n_i | input | 1 | DMA acknowledge, active low |
| dma_eot_n_i | input | 1 | DMA end-of-transfer, active low |
| dma_req_o | output | 1 | DMA request |

## Verification
The USB side ending a packet and the local side releasing the other buffer can land on the same clock edge, and both write the full-flag pair. The bench sets this up by leaving one byte of the first packet unread while the second packet is being written. It then drives `usb_eop_i` and the last `loc_rd_i` together. The case is judged correct when `buf_full_o` moves from 01 to 10, the new local count equals the second packet's length, and `loc_rdata_o` shows that packet's first byte. A second overlap, an accepted end-of-transfer that meets the crossing point of a DMA drain, is checked by `dma_req_o` falling on the next cycle while the other buffer still holds data.

// File: rtl/ep_pkg.sv
package ep_pkg;

    typedef enum logic {
        XFER_OUT = 1'b0,
        XFER_IN  = 1'b1
    } xfer_dir_e;

    // command to one side's pointer unit
    typedef struct packed {
        logic step;   // advance one byte
        logic swap;   // hand buffer over, move to the other one
    } ptr_cmd_t;

    function automatic int buf_capacity(input logic iso, input logic dual,
                                        input int bulk_bytes, input int iso_bytes);
        if (iso && !dual)
            return iso_bytes;
        return bulk_bytes;
    endfunction

endpackage

// File: rtl/ep_side_ptr.sv
module ep_side_ptr #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ep_pkg::ptr_cmd_t cmd_i,
    output logic             sel_o,
    output logic [PTR_W-1:0] ptr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_o <= 1'b0;
            ptr_o <= '0;
        end else if (cmd_i.swap) begin
            sel_o <= ~sel_o;
            ptr_o <= '0;
        end else if (cmd_i.step) begin
            ptr_o <= ptr_o + 1'b1;
        end
    end
endmodule

// File: rtl/ep_pingpong_ram.sv
module ep_pingpong_ram #(
    parameter int ADDR_W = 7
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic [ADDR_W:0] waddr_i,
    input  logic [7:0]      wdata_i,
    input  logic [ADDR_W:0] raddr_a_i,
    output logic [7:0]      rdata_a_o,
    input  logic [ADDR_W:0] raddr_b_i,
    output logic [7:0]      rdata_b_o
);
    localparam int WORDS = 2 ** (ADDR_W + 1);

    logic [7:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we_i)
            mem[waddr_i] <= wdata_i;
    end

    assign rdata_a_o = mem[raddr_a_i];
    assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/ep_dma_hs.sv
module ep_dma_hs (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic ack_n_i,
    input  logic eot_n_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic ready_i,
    output logic eot_ok_o,
    output logic req_o
);
    logic armed;

    assign eot_ok_o = !ack_n_i && !eot_n_i && (rd_i || wr_i);

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (eot_ok_o)
            armed <= 1'b0;
        else if (start_i)
            armed <= 1'b1;
    end

    assign req_o = armed && ready_i;
endmodule

// File: rtl/ep_dbuf_dma.sv
module ep_dbuf_dma #(
    parameter int BULK_BYTES = 64,
    parameter int ISO_BYTES  = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       iso_i,
    input  logic       iso_dual_i,
    input  logic       dir_in_i,
    input  logic       usb_wr_i,
    input  logic [7:0] usb_wdata_i,
    input  logic       usb_eop_i,
    input  logic       usb_rd_i,
    input  logic       usb_done_i,
    output logic [7:0] usb_rdata_o,
    output logic [$clog2(ISO_BYTES):0] usb_cnt_o,
    output logic       usb_nak_o,
    input  logic       loc_rd_i,
    input  logic       loc_wr_i,
    input  logic [7:0] loc_wdata_i,
    input  logic       loc_validate_i,
    output logic [7:0] loc_rdata_o,
    output logic [$clog2(ISO_BYTES):0] loc_cnt_o,
    output logic       loc_ready_o,
    output logic [1:0] buf_full_o,
    input  logic       dma_start_i,
    input  logic       dma_ack_n_i,
    input  logic       dma_eot_n_i,
    output logic       dma_req_o
);
    import ep_pkg::*;

    localparam int ADDR_W = $clog2(ISO_BYTES);
    localparam int CNT_W  = ADDR_W + 1;

    xfer_dir_e          dir;
    logic               is_out;
    logic [CNT_W-1:0]   cap;
    logic [1:0]         full_q;
    logic [CNT_W-1:0]   cnt_q [2];

    logic               usb_sel, loc_sel;
    logic [CNT_W-1:0]   usb_ptr, loc_ptr;
    ptr_cmd_t           usb_cmd, loc_cmd;

    logic usb_wr_ok, usb_pkt_end, usb_rd_ok, usb_free;
    logic loc_rd_ok, loc_release, loc_wr_ok, loc_commit, eot_ok;

    logic               mem_we;
    logic [ADDR_W:0]    mem_waddr;
    logic [7:0]         mem_wdata;

    assign dir    = xfer_dir_e'(dir_in_i);
    assign is_out = (dir == XFER_OUT);
    assign cap    = CNT_W'(buf_capacity(iso_i, iso_dual_i, BULK_BYTES, ISO_BYTES));

    // ---- OUT: USB writes, local reads ----
    assign usb_wr_ok   = is_out && usb_wr_i && !full_q[usb_sel] && (usb_ptr < cap);
    assign usb_pkt_end = is_out && usb_eop_i && !full_q[usb_sel];
    assign loc_rd_ok   = is_out && loc_rd_i && full_q[loc_sel];
    assign loc_release = loc_rd_ok &&
                         (((loc_ptr + CNT_W'(1)) >= cnt_q[loc_sel]) || eot_ok);

    // ---- IN: local writes, USB reads ----
    assign loc_wr_ok  = !is_out && loc_wr_i && !full_q[loc_sel] && (loc_ptr < cap);
    assign loc_commit = !is_out && !full_q[loc_sel] &&
                        (loc_validate_i ||
                         (loc_wr_ok && (((loc_ptr + CNT_W'(1)) == cap) || eot_ok)));
    assign usb_rd_ok  = !is_out && usb_rd_i && full_q[usb_sel] &&
                        (usb_ptr < cnt_q[usb_sel]);
    assign usb_free   = !is_out && usb_done_i && full_q[usb_sel];

    assign usb_cmd.step = usb_wr_ok || usb_rd_ok;
    assign usb_cmd.swap = usb_pkt_end || usb_free;
    assign loc_cmd.step = loc_rd_ok || loc_wr_ok;
    assign loc_cmd.swap = loc_release || loc_commit;

    ep_side_ptr #(.PTR_W(CNT_W)) i_usb_ptr (
        .clk(clk), .rst(rst), .cmd_i(usb_cmd), .sel_o(usb_sel), .ptr_o(usb_ptr)
    );

    ep_side_ptr #(.PTR_W(CNT_W)) i_loc_ptr (
        .clk(clk), .rst(rst), .cmd_i(loc_cmd), .sel_o(loc_sel), .ptr_o(loc_ptr)
    );

    // full flags and counts; the two sides never touch the same index in one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= '0;
            cnt_q  <= '{default: '0};
        end else begin
            if (usb_pkt_end) begin
                full_q[usb_sel] <= 1'b1;
                cnt_q[usb_sel]  <= usb_ptr + CNT_W'(usb_wr_ok);
            end
            if (loc_release)
                full_q[loc_sel] <= 1'b0;
            if (loc_commit) begin
                full_q[loc_sel] <= 1'b1;
                cnt_q[loc_sel]  <= loc_ptr + CNT_W'(loc_wr_ok);
            end
            if (usb_free)
                full_q[usb_sel] <= 1'b0;
        end
    end

    assign mem_we    = usb_wr_ok || loc_wr_ok;
    assign mem_waddr = is_out ? {usb_sel, usb_ptr[ADDR_W-1:0]}
                              : {loc_sel, loc_ptr[ADDR_W-1:0]};
    assign mem_wdata = is_out ? usb_wdata_i : loc_wdata_i;

    ep_pingpong_ram #(.ADDR_W(ADDR_W)) i_ram (
        .clk       (clk),
        .we_i      (mem_we),
        .waddr_i   (mem_waddr),
        .wdata_i   (mem_wdata),
        .raddr_a_i ({usb_sel, usb_ptr[ADDR_W-1:0]}),
        .rdata_a_o (usb_rdata_o),
        .raddr_b_i ({loc_sel, loc_ptr[ADDR_W-1:0]}),
        .rdata_b_o (loc_rdata_o)
    );

    ep_dma_hs i_dma (
        .clk     (clk),
        .rst     (rst),
        .start_i (dma_start_i),
        .ack_n_i (dma_ack_n_i),
        .eot_n_i (dma_eot_n_i),
        .rd_i    (loc_rd_i),
        .wr_i    (loc_wr_i),
        .ready_i (loc_ready_o),
        .eot_ok_o(eot_ok),
        .req_o   (dma_req_o)
    );

    assign loc_ready_o = is_out ? full_q[loc_sel] : !full_q[loc_sel];
    assign usb_nak_o   = is_out ? full_q[usb_sel] : !full_q[usb_sel];
    assign loc_cnt_o   = is_out ? cnt_q[loc_sel] : loc_ptr;
    assign usb_cnt_o   = is_out ? usb_ptr : cnt_q[usb_sel];
    assign buf_full_o  = full_q;
endmodule

// File: rtl/ep_dbuf_dma_chk.sv
module ep_dbuf_dma_chk #(
    parameter int BULK_BYTES = 64,
    parameter int ISO_BYTES  = 128
) (
    input logic       clk,
    input logic       rst,
    input logic       iso_i,
    input logic       iso_dual_i,
    input logic       dir_in_i,
    input logic       usb_eop_i,
    input logic       usb_done_i,
    input logic       loc_rd_i,
    input logic       loc_wr_i,
    input logic       loc_validate_i,
    input logic       dma_ack_n_i,
    input logic       dma_eot_n_i,
    input logic [$clog2(ISO_BYTES):0] usb_cnt_o,
    input logic [$clog2(ISO_BYTES):0] loc_cnt_o,
    input logic       usb_nak_o,
    input logic       loc_ready_o,
    input logic [1:0] buf_full_o,
    input logic       dma_req_o
);
    int cap;
    assign cap = ep_pkg::buf_capacity(iso_i, iso_dual_i, BULK_BYTES, ISO_BYTES);

    AST_FULL_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        !(usb_eop_i || usb_done_i || loc_rd_i || loc_wr_i || loc_validate_i)
        |=> $stable(buf_full_o)); // R1

    AST_COUNT_WITHIN_CAP: assert property (@(posedge clk) disable iff (rst)
        (int'(loc_cnt_o) <= cap) && (int'(usb_cnt_o) <= cap)); // R2

    AST_NAK_WHEN_BOTH_FULL: assert property (@(posedge clk) disable iff (rst)
        (!dir_in_i && buf_full_o == 2'b11) |-> usb_nak_o); // R5

    AST_NAK_WHEN_NONE_SENT: assert property (@(posedge clk) disable iff (rst)
        (dir_in_i && buf_full_o == 2'b00) |-> usb_nak_o); // R7

    AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        dma_req_o |-> loc_ready_o); // R8

    AST_REQ_DROPS_AFTER_EOT: assert property (@(posedge clk) disable iff (rst)
        (!dma_ack_n_i && !dma_eot_n_i && (loc_rd_i || loc_wr_i)) |=> !dma_req_o); // R9
endmodule

bind ep_dbuf_dma ep_dbuf_dma_chk #(.BULK_BYTES(BULK_BYTES), .ISO_BYTES(ISO_BYTES)) i_chk (.*);

// File: tb/test_ep_dbuf_dma.sv
module test_ep_dbuf_dma;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iso_i = 0, iso_dual_i = 0, dir_in_i = 0;
    logic usb_wr_i = 0, usb_eop_i = 0, usb_rd_i = 0, usb_done_i = 0;
    logic [7:0] usb_wdata_i = 0, loc_wdata_i = 0;
    logic loc_rd_i = 0, loc_wr_i = 0, loc_validate_i = 0;
    logic dma_start_i = 0, dma_ack_n_i = 1, dma_eot_n_i = 1;
    logic [7:0] usb_rdata_o, loc_rdata_o;
    logic [CNT_W-1:0] usb_cnt_o, loc_cnt_o;
    logic usb_nak_o, loc_ready_o, dma_req_o;
    logic [1:0] buf_full_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ep_dbuf_dma i_ep_dbuf_dma (.*);

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 29 + i * 7 + 3);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic iso, input logic dual, input logic din);
        rst = 1; iso_i = iso; iso_dual_i = dual; dir_in_i = din;
        tick(); tick();
        rst = 0;
    endtask

    task automatic usb_send(input int seed, input int len, input bit eop);
        for (int i = 0; i < len; i++) begin
            usb_wr_i = 1; usb_wdata_i = pat(seed, i);
            tick();
        end
        usb_wr_i = 0;
        if (eop) begin
            usb_eop_i = 1; tick(); usb_eop_i = 0;
        end
    endtask

    task automatic loc_drain(input int seed, input int len, input string tag);
        chk_eq({tag, " ready"}, int'(loc_ready_o), 1);
        chk_eq({tag, " count"}, int'(loc_cnt_o), len);
        for (int i = 0; i < len; i++) begin
            chk_eq({tag, " data"}, int'(loc_rdata_o), int'(pat(seed, i)));
            loc_rd_i = 1; tick();
        end
        loc_rd_i = 0;
    endtask

    task automatic loc_fill(input int seed, input int len);
        for (int i = 0; i < len; i++) begin
            loc_wr_i = 1; loc_wdata_i = pat(seed, i);
            tick();
        end
        loc_wr_i = 0;
    endtask

    task automatic usb_fetch(input int seed, input int len, input string tag);
        chk_eq({tag, " nak"}, int'(usb_nak_o), 0);
        chk_eq({tag, " count"}, int'(usb_cnt_o), len);
        for (int i = 0; i < len; i++) begin
            chk_eq({tag, " data"}, int'(usb_rdata_o), int'(pat(seed, i)));
            usb_rd_i = 1; tick();
        end
        usb_rd_i = 0;
        usb_done_i = 1; tick(); usb_done_i = 0;
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        do_reset(0, 0, 0);
        chk_eq("R12 buf_full", int'(buf_full_o), 0);
        chk_eq("R12 req", int'(dma_req_o), 0);
        chk_eq("R12 nak", int'(usb_nak_o), 0);
        chk_eq("R12 ready", int'(loc_ready_o), 0);
        chk_eq("R12 loc_cnt", int'(loc_cnt_o), 0);

        // R2 R3 R4 sizing sweep over the three modes and several lengths
        for (int m = 0; m < 3; m++) begin
            int cap;
            cap = (m == 1) ? 128 : 64;
            do_reset(m != 0, m == 2, 0);
            for (int k = 0; k < 4; k++) begin
                int len;
                len = (k == 0) ? 1 : (k == 1) ? cap - 1 : (k == 2) ? cap : cap + 3;
                usb_send(10 + k, len, 1);
                chk_eq("R3 full after eop", int'($countones(buf_full_o)), 1);
                loc_drain(10 + k, (len > cap) ? cap : len, "R2 R4 drain");
                chk_eq("R4 released", int'(loc_ready_o), 0);
            end
        end

        // R5 both full: further data rejected
        do_reset(0, 0, 0);
        usb_send(30, 5, 1);
        usb_send(31, 6, 1);
        chk_eq("R1 both full", int'(buf_full_o), 3);
        chk_eq("R5 nak", int'(usb_nak_o), 1);
        usb_send(32, 4, 1);
        chk_eq("R5 still full", int'(buf_full_o), 3);
        loc_drain(30, 5, "R5 first intact");
        chk_eq("R1 swap", int'(buf_full_o), 2);
        chk_eq("R5 nak clears", int'(usb_nak_o), 0);
        loc_drain(31, 6, "R5 second intact");
        chk_eq("R1 both empty", int'(buf_full_o), 0);

        // R11 packet end and release in the same cycle
        do_reset(0, 0, 0);
        usb_send(40, 4, 1);
        usb_send(41, 3, 0);
        for (int i = 0; i < 3; i++) begin
            loc_rd_i = 1; tick();
        end
        chk_eq("R11 before", int'(buf_full_o), 1);
        chk_eq("R11 last byte", int'(loc_rdata_o), int'(pat(40, 3)));
        usb_eop_i = 1; loc_rd_i = 1; tick();
        usb_eop_i = 0; loc_rd_i = 0;
        chk_eq("R11 after", int'(buf_full_o), 2);
        chk_eq("R11 count", int'(loc_cnt_o), 3);
        chk_eq("R11 data", int'(loc_rdata_o), int'(pat(41, 0)));
        loc_drain(41, 3, "R11 drain");

        // R8 R10 DMA drain crossing both buffers
        do_reset(0, 0, 0);
        chk_eq("R8 idle", int'(dma_req_o), 0);
        usb_send(50, 10, 1);
        usb_send(51, 7, 1);
        chk_eq("R8 not armed", int'(dma_req_o), 0);
        dma_start_i = 1; tick(); dma_start_i = 0;
        chk_eq("R8 req", int'(dma_req_o), 1);
        for (int i = 0; i < 17; i++) begin
            chk_eq("R10 data", int'(loc_rdata_o),
                   int'((i < 10) ? pat(50, i) : pat(51, i - 10)));
            chk_eq("R10 req held", int'(dma_req_o), 1);
            dma_ack_n_i = 0; loc_rd_i = 1; tick();
        end
        dma_ack_n_i = 1; loc_rd_i = 0;
        chk_eq("R10 all drained", int'(buf_full_o), 0);
        chk_eq("R8 req low empty", int'(dma_req_o), 0);

        // R9 end-of-transfer qualification (still armed)
        usb_send(52, 8, 1);
        usb_send(53, 5, 1);
        chk_eq("R8 req again", int'(dma_req_o), 1);
        dma_eot_n_i = 0; loc_rd_i = 1; tick();   // ack high: not accepted
        dma_eot_n_i = 1; loc_rd_i = 0;
        chk_eq("R9 eot w/o ack ignored", int'(buf_full_o), 3);
        chk_eq("R9 req kept", int'(dma_req_o), 1);
        chk_eq("R9 byte1", int'(loc_rdata_o), int'(pat(52, 1)));
        dma_ack_n_i = 0; dma_eot_n_i = 0; tick(); // no strobe: not accepted
        dma_ack_n_i = 1; dma_eot_n_i = 1;
        chk_eq("R9 eot w/o strobe", int'(dma_req_o), 1);
        dma_ack_n_i = 0; dma_eot_n_i = 0; loc_rd_i = 1; tick();
        dma_ack_n_i = 1; dma_eot_n_i = 1; loc_rd_i = 0;
        chk_eq("R9 release", int'(buf_full_o), 2);
        chk_eq("R9 req low", int'(dma_req_o), 0);
        chk_eq("R9 ready", int'(loc_ready_o), 1);
        loc_drain(53, 5, "R9 next packet");

        // R6 R7 IN direction, bulk sizing
        do_reset(0, 0, 1);
        chk_eq("R7 nak empty", int'(usb_nak_o), 1);
        chk_eq("R6 ready", int'(loc_ready_o), 1);
        loc_fill(60, 5);
        chk_eq("R6 written", int'(loc_cnt_o), 5);
        chk_eq("R6 not yet", int'(buf_full_o), 0);
        loc_validate_i = 1; tick(); loc_validate_i = 0;
        chk_eq("R6 validated", int'(buf_full_o), 1);
        loc_fill(61, 64);
        chk_eq("R6 auto commit", int'(buf_full_o), 3);
        chk_eq("R6 no space", int'(loc_ready_o), 0);
        loc_fill(62, 1);
        usb_fetch(60, 5, "R7 first");
        chk_eq("R7 freed", int'(buf_full_o), 2);
        usb_fetch(61, 64, "R7 second");
        chk_eq("R7 nak again", int'(usb_nak_o), 1);

        // R9 DMA fill ended by end-of-transfer
        dma_start_i = 1; tick(); dma_start_i = 0;
        chk_eq("R8 in req", int'(dma_req_o), 1);
        for (int i = 0; i < 3; i++) begin
            dma_ack_n_i = 0; dma_eot_n_i = (i == 2) ? 1'b0 : 1'b1;
            loc_wr_i = 1; loc_wdata_i = pat(63, i);
            tick();
        end
        dma_ack_n_i = 1; dma_eot_n_i = 1; loc_wr_i = 0;
        chk_eq("R9 in commit", int'(buf_full_o), 1);
        chk_eq("R9 in req low", int'(dma_req_o), 0);
        usb_fetch(63, 3, "R9 in data");

        // R2 R6 isochronous single direction, 128-byte buffer
        do_reset(1, 0, 1);
        loc_fill(70, 128);
        chk_eq("R2 iso commit", int'(buf_full_o), 1);
        usb_fetch(70, 128, "R2 iso data");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule